// File: doc/BRIEF.md
# Display Raster Timing Generator

This block walks a parallel LCD panel through its raster. On every clock where the pixel-step enable is high it moves one pixel position. From that position it produces horizontal sync, vertical sync, a data-enable strobe and the coordinates of the current pixel inside the visible area. A horizontal counter advances once per step. A vertical counter advances once each time the horizontal counter wraps, so it counts whole lines.

Each axis has its own five lengths. In time order they are: a lead-in before sync, the sync pulse, the back porch, the visible span and the front porch. The block adds these lengths into phase boundaries as soon as they arrive on its inputs. It stores the boundaries, and the data-enable mode, in a shadow set that is replaced only on the step where both counters return to the frame origin. The panel therefore never sees a frame that mixes old and new timing. The two sync-polarity bits are not shadowed. They act at once, so the sync level during and straight after reset matches the way the board is wired.

Top module: `raster_timer`

## Requirements
- R1: While reset is held, and until the first pixel step after it, hsync equals hsync_inv, vsync equals vsync_inv, de is 0, and pix_x and pix_y are 0.
- R2: The horizontal position rises by one on each clock with pix_en high. It holds on each clock with pix_en low. It returns to 0 after the step that reaches position (sum of the five horizontal lengths) minus 1.
- R3: The sync region covers horizontal positions from h_ref_len up to, but not including, h_ref_len+h_sync_len. hsync is high in that region and low outside it when hsync_inv=0, and inverted when hsync_inv=1. A change of hsync_inv shows on hsync in the same cycle.
- R4: The visible span starts at position P = h_ref_len+h_sync_len+h_back_len and runs for h_act_len positions. Inside it pix_x = position − P. Outside it pix_x = 0.
- R5: The line counter advances once per horizontal wrap and returns to 0 after line (sum of the five vertical lengths) minus 1. vsync is asserted on lines from v_ref_len up to, but not including, v_ref_len+v_sync_len, with the polarity set by vsync_inv.
- R6: Inside the visible lines, which start at Q = v_ref_len+v_sync_len+v_back_len and run for v_act_len lines, pix_y = line − Q. Outside them pix_y = 0.
- R7: With de_mode code 1, de is 1 exactly when both the horizontal and the vertical position lie in their visible spans.
- R8: With de_mode code 0, de is 1 in the horizontal visible span of every line, including the lines of vertical blanking.
- R9: With de_mode code 2, de is the inverse of the code 1 strobe (active low). With code 3, de stays 0.
- R10: Lengths and de_mode changed during a frame have no effect on any output until the step that takes both counters to the origin. From the next cycle on, the new values apply.
- R11: Any length may be 0. Its phase is then skipped without a lost step. An axis whose five lengths are all 0 stays at position 0 and wraps on every step it receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Advance one pixel position this cycle |
| h_ref_len | input | 13 | Horizontal lead-in before sync |
| h_sync_len | input | 13 | Horizontal sync width |
| h_back_len | input | 13 | Horizontal back porch |
| h_act_len | input | 13 | Visible pixels per line |
| h_front_len | input | 13 | Horizontal front porch |
| v_ref_len | input | 13 | Vertical lead-in in lines |
| v_sync_len | input | 13 | Vertical sync width in lines |
| v_back_len | input | 13 | Vertical back porch in lines |
| v_act_len | input | 13 | Visible lines per frame |
| v_front_len | input | 13 | Vertical front porch in lines |
| de_mode | input | 2 | Data-enable mode (0 line span, 1 visible area, 2 visible area active low, 3 off) |
| hsync_inv | input | 1 | Invert horizontal sync |
| vsync_inv | input | 1 | Invert vertical sync |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 13 | Column inside the visible span |
| pix_y | output | 13 | Row inside the visible lines |

## Verification
Two events can land on the same edge: the shadow commit of new timing and the wrap of both counters. The commit is also what starts the next frame's phases. The bench changes the lengths in the middle of a frame, so the commit meets the first positions of the new frame. In one stimulus set every vertical length is 0, which makes each line end a frame end, so a commit occurs on every horizontal wrap. A step-by-step reference model built from the requirements reads the inputs at the same edge as the design and compares every output in every cycle. A commit that comes one step early or late shows up as a wrong sync, data-enable or coordinate value.

// File: rtl/raster_pkg.sv
package raster_pkg;
    // Width of one programmed length; counters carry room for the sum of five.
    parameter int RT_PW = 13;
    parameter int RT_CW = RT_PW + 3;
    localparam int RT_AXES   = 2;
    localparam int RT_PHASES = 5;

    typedef logic [RT_PW-1:0] len_t;
    typedef logic [RT_CW-1:0] cnt_t;

    // Cumulative phase boundaries of one axis.
    typedef struct packed {
        cnt_t sync_lo;
        cnt_t sync_hi;
        cnt_t act_lo;
        cnt_t act_hi;
        cnt_t total;
    } bounds_t;

    typedef enum logic [1:0] {
        DE_LINE_SPAN  = 2'd0,
        DE_VISIBLE    = 2'd1,
        DE_VISIBLE_LO = 2'd2,
        DE_OFF        = 2'd3
    } de_mode_e;
endpackage

// File: rtl/raster_bounds.sv
module raster_bounds
    import raster_pkg::*;
(
    input  len_t    ref_len,
    input  len_t    sync_len,
    input  len_t    back_len,
    input  len_t    act_len,
    input  len_t    front_len,
    output bounds_t bnd
);
    // Running sum of the five lengths, widened to counter width.
    always_comb begin
        bnd.sync_lo = cnt_t'(ref_len);
        bnd.sync_hi = bnd.sync_lo + cnt_t'(sync_len);
        bnd.act_lo  = bnd.sync_hi + cnt_t'(back_len);
        bnd.act_hi  = bnd.act_lo  + cnt_t'(act_len);
        bnd.total   = bnd.act_hi  + cnt_t'(front_len);
    end
endmodule

// File: rtl/raster_shadow.sv
module raster_shadow
    import raster_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit,
    input  bounds_t  h_new,
    input  bounds_t  v_new,
    input  de_mode_e de_new,
    output bounds_t  h_cur,
    output bounds_t  v_cur,
    output de_mode_e de_cur
);
    typedef struct packed {
        bounds_t  h;
        bounds_t  v;
        de_mode_e de;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (commit) begin
            sh_d.h  = h_new;
            sh_d.v  = v_new;
            sh_d.de = de_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.h  <= '0;
            sh_q.v  <= '0;
            sh_q.de <= DE_VISIBLE;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign h_cur  = sh_q.h;
    assign v_cur  = sh_q.v;
    assign de_cur = sh_q.de;

    // Timing in use never moves between frame boundaries.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(sh_q));
    // A boundary installs exactly what was presented on that edge.
    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (sh_q.h == $past(h_new)) && (sh_q.v == $past(v_new)));
endmodule

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    step,
    input  bounds_t bnd,
    output cnt_t    pos,
    output logic    last,
    output logic    in_sync,
    output logic    in_act,
    output len_t    rel
);
    typedef struct packed {
        cnt_t pos;
    } axis_t;

    axis_t           ax_d, ax_q;
    logic [RT_CW:0]  nxt_wide;

    always_comb begin
        nxt_wide = {1'b0, ax_q.pos} + 1'b1;
        // A zero total makes every position the last one.
        last     = nxt_wide >= {1'b0, bnd.total};
        ax_d     = ax_q;
        if (step) begin
            ax_d.pos = last ? '0 : nxt_wide[RT_CW-1:0];
        end
        in_sync = (ax_q.pos >= bnd.sync_lo) && (ax_q.pos < bnd.sync_hi);
        in_act  = (ax_q.pos >= bnd.act_lo)  && (ax_q.pos < bnd.act_hi);
        rel     = in_act ? len_t'(ax_q.pos - bnd.act_lo) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ax_q.pos <= '0;
        end else begin
            ax_q <= ax_d;
        end
    end

    assign pos = ax_q.pos;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ax_q.pos));
    assert_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> (ax_q.pos == $past(ax_q.pos) + 1'b1));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (ax_q.pos == '0));
    // Bounds only change at the origin, so the counter never leaves the period.
    assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_q.pos < bnd.total) || (ax_q.pos == '0));
endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [RT_PW-1:0] h_ref_len,
    input  logic [RT_PW-1:0] h_sync_len,
    input  logic [RT_PW-1:0] h_back_len,
    input  logic [RT_PW-1:0] h_act_len,
    input  logic [RT_PW-1:0] h_front_len,
    input  logic [RT_PW-1:0] v_ref_len,
    input  logic [RT_PW-1:0] v_sync_len,
    input  logic [RT_PW-1:0] v_back_len,
    input  logic [RT_PW-1:0] v_act_len,
    input  logic [RT_PW-1:0] v_front_len,
    input  logic [1:0]       de_mode,
    input  logic             hsync_inv,
    input  logic             vsync_inv,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [RT_PW-1:0] pix_x,
    output logic [RT_PW-1:0] pix_y
);
    len_t     lens    [RT_AXES][RT_PHASES];
    bounds_t  bnd_new [RT_AXES];
    bounds_t  bnd_cur [RT_AXES];
    logic     step_a  [RT_AXES];
    logic     last_a  [RT_AXES];
    logic     sync_a  [RT_AXES];
    logic     act_a   [RT_AXES];
    cnt_t     pos_a   [RT_AXES];
    len_t     rel_a   [RT_AXES];
    de_mode_e de_cur;
    logic     commit;
    logic     both_act;

    assign lens[0][0] = h_ref_len;
    assign lens[0][1] = h_sync_len;
    assign lens[0][2] = h_back_len;
    assign lens[0][3] = h_act_len;
    assign lens[0][4] = h_front_len;
    assign lens[1][0] = v_ref_len;
    assign lens[1][1] = v_sync_len;
    assign lens[1][2] = v_back_len;
    assign lens[1][3] = v_act_len;
    assign lens[1][4] = v_front_len;

    // Horizontal steps on every enable; vertical steps on the horizontal wrap.
    assign step_a[0] = pix_en;
    assign step_a[1] = pix_en & last_a[0];
    assign commit    = pix_en & last_a[0] & last_a[1];

    for (genvar g = 0; g < RT_AXES; g++) begin : g_axis
        raster_bounds u_bounds (
            .ref_len   (lens[g][0]),
            .sync_len  (lens[g][1]),
            .back_len  (lens[g][2]),
            .act_len   (lens[g][3]),
            .front_len (lens[g][4]),
            .bnd       (bnd_new[g])
        );
        raster_axis u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step_a[g]),
            .bnd     (bnd_cur[g]),
            .pos     (pos_a[g]),
            .last    (last_a[g]),
            .in_sync (sync_a[g]),
            .in_act  (act_a[g]),
            .rel     (rel_a[g])
        );
    end

    raster_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .h_new  (bnd_new[0]),
        .v_new  (bnd_new[1]),
        .de_new (de_mode_e'(de_mode)),
        .h_cur  (bnd_cur[0]),
        .v_cur  (bnd_cur[1]),
        .de_cur (de_cur)
    );

    always_comb begin
        both_act = act_a[0] & act_a[1];
        hsync    = sync_a[0] ^ hsync_inv;
        vsync    = sync_a[1] ^ vsync_inv;
        unique case (de_cur)
            DE_LINE_SPAN:  de = act_a[0];
            DE_VISIBLE:    de = both_act;
            DE_VISIBLE_LO: de = ~both_act;
            default:       de = 1'b0;
        endcase
        pix_x = rel_a[0];
        pix_y = rel_a[1];
    end

    // The frame boundary puts both counters at the origin together.
    assert_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (pos_a[0] == '0) && (pos_a[1] == '0));
    // The line counter only moves when the pixel counter has just wrapped.
    assert_line_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_a[1] != $past(pos_a[1])) |-> ($past(pix_en) && (pos_a[0] == '0)));
endmodule

// File: tb/raster_timer_tb.sv
module raster_timer_tb;
    import raster_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 5;
    localparam int NFLD       = 13;
    localparam int RUN_CYC    = 260;
    // h ref,sync,back,act,front | v ref,sync,back,act,front | de_mode, hinv, vinv
    localparam int VEC [NVEC][NFLD] = '{
        '{2, 3, 2, 5, 1,  1, 2, 1, 3, 1,  1, 0, 0},
        '{0, 2, 0, 3, 0,  0, 1, 2, 2, 0,  0, 1, 0},
        '{1, 1, 1, 4, 2,  2, 1, 1, 2, 2,  2, 0, 1},
        '{3, 2, 1, 2, 1,  0, 0, 0, 0, 0,  0, 1, 1},
        '{1, 2, 3, 4, 1,  1, 1, 1, 2, 1,  3, 0, 0}
    };

    logic clk = 1'b0;
    logic rst_n, pix_en;
    logic [RT_PW-1:0] h_ref_len, h_sync_len, h_back_len, h_act_len, h_front_len;
    logic [RT_PW-1:0] v_ref_len, v_sync_len, v_back_len, v_act_len, v_front_len;
    logic [1:0] de_mode;
    logic hsync_inv, vsync_inv;
    logic hsync, vsync, de;
    logic [RT_PW-1:0] pix_x, pix_y;

    int n_chk = 0;
    int n_fail = 0;
    int m_len [2][5];
    int m_h, m_v, m_de;
    bit pending;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timer u_dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .h_ref_len(h_ref_len), .h_sync_len(h_sync_len), .h_back_len(h_back_len),
        .h_act_len(h_act_len), .h_front_len(h_front_len),
        .v_ref_len(v_ref_len), .v_sync_len(v_sync_len), .v_back_len(v_back_len),
        .v_act_len(v_act_len), .v_front_len(v_front_len),
        .de_mode(de_mode), .hsync_inv(hsync_inv), .vsync_inv(vsync_inv),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int tot(input int a);
        return m_len[a][0] + m_len[a][1] + m_len[a][2] + m_len[a][3] + m_len[a][4];
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 2; a++)
            for (int p = 0; p < 5; p++) m_len[a][p] = 0;
        m_h = 0; m_v = 0; m_de = 1;
    endtask

    task automatic model_load();
        m_len[0][0] = int'(h_ref_len);  m_len[0][1] = int'(h_sync_len);
        m_len[0][2] = int'(h_back_len); m_len[0][3] = int'(h_act_len);
        m_len[0][4] = int'(h_front_len);
        m_len[1][0] = int'(v_ref_len);  m_len[1][1] = int'(v_sync_len);
        m_len[1][2] = int'(v_back_len); m_len[1][3] = int'(v_act_len);
        m_len[1][4] = int'(v_front_len);
        m_de = int'(de_mode);
        pending = 1'b0;
    endtask

    // Called just after a rising edge with the inputs that edge saw.
    task automatic model_step();
        if (pix_en) begin
            if (m_h + 1 >= tot(0)) begin
                m_h = 0;
                if (m_v + 1 >= tot(1)) begin
                    m_v = 0;
                    model_load();
                end else begin
                    m_v++;
                end
            end else begin
                m_h++;
            end
        end
    endtask

    task automatic compare_all();
        int s0, s1, a0, a1, t0, t1, t2, t3;
        bit ha, va, e_de;
        string sfx;
        s0 = m_len[0][0]; s1 = s0 + m_len[0][1]; a0 = s1 + m_len[0][2]; a1 = a0 + m_len[0][3];
        t0 = m_len[1][0]; t1 = t0 + m_len[1][1]; t2 = t1 + m_len[1][2]; t3 = t2 + m_len[1][3];
        ha = (m_h >= a0) && (m_h < a1);
        va = (m_v >= t2) && (m_v < t3);
        sfx = pending ? " R10 pending" : "";
        for (int a = 0; a < 2; a++)
            for (int p = 0; p < 5; p++)
                if (m_len[a][p] == 0) sfx = {sfx, " R11"};
        chk({"R3 hsync", sfx}, int'(hsync), int'(((m_h >= s0) && (m_h < s1)) ^ hsync_inv));
        chk({"R5 vsync", sfx}, int'(vsync), int'(((m_v >= t0) && (m_v < t1)) ^ vsync_inv));
        chk({"R2 R4 pix_x", sfx}, int'(pix_x), ha ? m_h - a0 : 0);
        chk({"R6 pix_y", sfx}, int'(pix_y), va ? m_v - t2 : 0);
        case (m_de)
            0: begin e_de = ha;        chk({"R8 de", sfx}, int'(de), int'(e_de)); end
            1: begin e_de = ha && va;  chk({"R7 de", sfx}, int'(de), int'(e_de)); end
            2: begin e_de = !(ha && va); chk({"R9 de low", sfx}, int'(de), int'(e_de)); end
            default: chk({"R9 de off", sfx}, int'(de), 0);
        endcase
    endtask

    task automatic cycle(input bit en);
        @(negedge clk);
        compare_all();
        pix_en = en;
        @(posedge clk);
        model_step();
    endtask

    task automatic apply_vec(input int v);
        h_ref_len  = len_t'(VEC[v][0]);  h_sync_len  = len_t'(VEC[v][1]);
        h_back_len = len_t'(VEC[v][2]);  h_act_len   = len_t'(VEC[v][3]);
        h_front_len = len_t'(VEC[v][4]);
        v_ref_len  = len_t'(VEC[v][5]);  v_sync_len  = len_t'(VEC[v][6]);
        v_back_len = len_t'(VEC[v][7]);  v_act_len   = len_t'(VEC[v][8]);
        v_front_len = len_t'(VEC[v][9]);
        de_mode = 2'(VEC[v][10]);
        hsync_inv = 1'(VEC[v][11]);
        vsync_inv = 1'(VEC[v][12]);
        pending = 1'b1;
    endtask

    task automatic check_reset_state(input string where);
        chk({"R1 hsync idle ", where}, int'(hsync), int'(hsync_inv));
        chk({"R1 vsync idle ", where}, int'(vsync), int'(vsync_inv));
        chk({"R1 de idle ", where}, int'(de), 0);
        chk({"R1 pix_x idle ", where}, int'(pix_x), 0);
        chk({"R1 pix_y idle ", where}, int'(pix_y), 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        pix_en = 1'b0;
        apply_vec(0);
        hsync_inv = 1'b1;   // idle level must follow the live polarity bit
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("in reset");
        rst_n = 1'b1;
        hsync_inv = 1'b0;
        @(negedge clk);
        check_reset_state("before first step");

        // Table walk: each set is presented mid-frame of the previous one.
        for (int v = 0; v < NVEC; v++) begin
            apply_vec(v);
            for (int c = 0; c < RUN_CYC; c++) cycle((c % 4) != 3);
        end

        // R2: outputs frozen while the step enable stays low.
        apply_vec(0);
        for (int c = 0; c < 150; c++) cycle(1'b1);
        begin
            int sx, sy, shs;
            @(negedge clk);
            sx = int'(pix_x); sy = int'(pix_y); shs = int'(hsync);
            pix_en = 1'b0;
            repeat (6) @(posedge clk);
            @(negedge clk);
            chk("R2 hold pix_x", int'(pix_x), sx);
            chk("R2 hold pix_y", int'(pix_y), sy);
            chk("R2 hold hsync", int'(hsync), shs);
            // R3: polarity flip shows in the same cycle.
            hsync_inv = ~hsync_inv;
            #1;
            chk("R3 live polarity", int'(hsync), shs ^ 1);
            hsync_inv = ~hsync_inv;
        end
        for (int c = 0; c < 40; c++) cycle(1'b1);

        // R1: reset in the middle of a frame.
        @(negedge clk);
        rst_n = 1'b0;
        pix_en = 1'b0;
        model_reset();
        @(negedge clk);
        check_reset_state("mid-run reset");
        rst_n = 1'b1;
        for (int c = 0; c < 60; c++) cycle(1'b1);

        finish_run();
    end
endmodule